// File: doc/BRIEF.md
# SPI command frame builder

This block produces the command phase of a register and block access protocol that runs over SPI. A requester presents an opcode together with an address, a write data word, a transfer size and two option flags, and pulses a start strobe. The block latches these fields, works out the frame layout for that opcode, and sends the frame one byte at a time on a valid/ready byte stream. The stream feeds an SPI shift register, which is outside this block. Response parsing and the data phase are also outside it.

The frame length and the fields it carries depend on the opcode. When the CRC option is on, one extra byte follows the frame. It holds a 7-bit CRC over every byte that came before it. The CRC option is taken per frame at start time, so software can turn the check off at run time. An opcode the block does not recognise produces a one-cycle error pulse, and no bytes are sent for it.

Top module: `spi_cmd_framer`

## Requirements
- R1: Seven opcodes are recognised: 0xC3 internal write, 0xC4 internal read, 0xC7 extended block write, 0xC8 extended block read, 0xC9 single write, 0xCA single read, 0xCF reset. Every frame starts with the opcode byte. Without the trailer, the lengths are 4 bytes for internal read, single read and reset, 7 bytes for internal write and both block commands, and 8 bytes for single write.
- R2: Single read sends address[23:16], address[15:8] and address[7:0] after the opcode. Both block commands send the same three address bytes and then size[23:16], size[15:8] and size[7:0].
- R3: Internal read sends address[15:8], address[7:0] and one 0x00 byte after the opcode. Internal write sends the same two address bytes and then data[31:24], data[23:16], data[15:8] and data[7:0]. For both internal commands, bit 7 of the first address byte is forced to 1 when the clockless flag is set.
- R4: Reset sends three 0xFF bytes after the opcode, whatever the field inputs hold.
- R5: Single write sends the three address bytes and then the four data bytes after the opcode, each field most significant byte first.
- R6: With CRC enabled, one trailer byte follows the frame. Its bits 7..1 hold a CRC7 over all earlier frame bytes, with polynomial x^7+x^3+1, register preset 0x7F and bits fed most significant first. Its bit 0 is 0.
- R7: With CRC disabled, no trailer byte is sent, so the frame is exactly the R1 length.
- R8: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o does not change in the next cycle.
- R9: done_o is high for exactly one cycle, in the cycle after the last byte is accepted. tx_valid_o is low in that cycle.
- R10: A start with an unrecognised opcode raises err_o for one cycle in the next cycle, and tx_valid_o stays low.
- R11: A start received while a frame is being sent is ignored. The frame in progress continues unchanged.
- R12: After reset, tx_valid_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; fields are latched when idle |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Access address |
| wdata_i | input | 32 | Write data word |
| size_i | input | 24 | Block transfer size |
| clockless_i | input | 1 | Set bit 7 of first address byte on internal commands |
| crc_en_i | input | 1 | Append CRC7 trailer byte |
| tx_valid_o | output | 1 | Byte available on tx_data_o |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| tx_data_o | output | 8 | Frame byte |
| done_o | output | 1 | One-cycle pulse after the last byte is accepted |
| err_o | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
The bench builds the block with the default CRC preset of 0x7F. This is the preset the protocol uses, so every trailer the bench computes matches what a real target checks. The frame layout is fixed by the protocol, and the package constants give a longest body of eight bytes. With those values, every opcode can be exercised with random fields, random backpressure and the CRC option both on and off. Unknown opcodes and restarts in the middle of a frame are covered as well.

// File: rtl/spi_cmd_framer_pkg.sv
// Shared constants and types for the SPI command frame builder.
// Assumes byte-wide output stream and a fixed protocol field layout.
package spi_cmd_framer_pkg;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 32;
    localparam int SIZE_W   = 24;
    localparam int MAX_BODY = 8;                      // longest frame without trailer
    localparam int CNT_W    = $clog2(MAX_BODY + 2);   // counts body plus trailer
    localparam int SEL_W    = $clog2(MAX_BODY);       // selects a body byte

    typedef logic [MAX_BODY-1:0][7:0] body_t;

    typedef enum logic [7:0] {
        OP_INT_WR = 8'hC3,
        OP_INT_RD = 8'hC4,
        OP_BLK_WR = 8'hC7,
        OP_BLK_RD = 8'hC8,
        OP_SGL_WR = 8'hC9,
        OP_SGL_RD = 8'hCA,
        OP_RESET  = 8'hCF
    } opcode_e;
endpackage

// File: rtl/spi_cmd_framer_layout.sv
// Frame layout decoder: maps an opcode and its fields to the ordered body
// bytes and the body length. Purely combinational; assumes fields are stable.
module spi_cmd_framer_layout
    import spi_cmd_framer_pkg::*;
(
    input  logic [7:0]        opcode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              clockless_i,
    output body_t             body_o,
    output logic [CNT_W-1:0]  len_o,
    output logic              known_o
);
    // Internal commands carry a 16-bit address with the clockless marker on top.
    logic [7:0] int_hi;
    assign int_hi = {addr_i[15] | clockless_i, addr_i[14:8]};

    // Select field order and length per opcode.
    always_comb begin
        body_o    = '0;
        len_o     = '0;
        known_o   = 1'b1;
        body_o[0] = opcode_i;
        case (opcode_i)
            OP_SGL_RD: begin
                body_o[1] = addr_i[23:16];
                body_o[2] = addr_i[15:8];
                body_o[3] = addr_i[7:0];
                len_o     = CNT_W'(4);
            end
            OP_BLK_RD, OP_BLK_WR: begin
                body_o[1] = addr_i[23:16];
                body_o[2] = addr_i[15:8];
                body_o[3] = addr_i[7:0];
                body_o[4] = size_i[23:16];
                body_o[5] = size_i[15:8];
                body_o[6] = size_i[7:0];
                len_o     = CNT_W'(7);
            end
            OP_INT_RD: begin
                body_o[1] = int_hi;
                body_o[2] = addr_i[7:0];
                body_o[3] = 8'h00;
                len_o     = CNT_W'(4);
            end
            OP_INT_WR: begin
                body_o[1] = int_hi;
                body_o[2] = addr_i[7:0];
                body_o[3] = wdata_i[31:24];
                body_o[4] = wdata_i[23:16];
                body_o[5] = wdata_i[15:8];
                body_o[6] = wdata_i[7:0];
                len_o     = CNT_W'(7);
            end
            OP_SGL_WR: begin
                body_o[1] = addr_i[23:16];
                body_o[2] = addr_i[15:8];
                body_o[3] = addr_i[7:0];
                body_o[4] = wdata_i[31:24];
                body_o[5] = wdata_i[23:16];
                body_o[6] = wdata_i[15:8];
                body_o[7] = wdata_i[7:0];
                len_o     = CNT_W'(8);
            end
            OP_RESET: begin
                body_o[1] = 8'hFF;
                body_o[2] = 8'hFF;
                body_o[3] = 8'hFF;
                len_o     = CNT_W'(4);
            end
            default: begin
                body_o  = '0;
                known_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/spi_cmd_framer_crc7.sv
// One-byte CRC7 step, polynomial x^7+x^3+1, bits taken MSB first.
// Combinational; the caller holds the running register.
module spi_cmd_framer_crc7 (
    input  logic [6:0] crc_i,
    input  logic [7:0] byte_i,
    output logic [6:0] crc_o
);
    // Shift eight data bits through the 7-bit LFSR.
    always_comb begin
        logic [6:0] r;
        logic       fb;
        r = crc_i;
        for (int b = 7; b >= 0; b--) begin
            fb = r[6] ^ byte_i[b];
            r  = {r[5:0], 1'b0};
            if (fb) r = r ^ 7'h09;
        end
        crc_o = r;
    end
endmodule

// File: rtl/spi_cmd_framer.sv
// SPI command frame builder top. Latches a command on start while idle,
// streams the body bytes and an optional CRC7 trailer on a valid/ready
// byte interface, then pulses done. Unknown opcodes pulse err and send
// nothing. Assumes the downstream shifter honours valid/ready.
module spi_cmd_framer
    import spi_cmd_framer_pkg::*;
#(
    parameter logic [6:0] CRC_PRESET = 7'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              clockless_i,
    input  logic              crc_en_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [7:0]        tx_data_o,
    output logic              done_o,
    output logic              err_o
);
    body_t            lay_body;
    logic [CNT_W-1:0] lay_len;
    logic             lay_known;

    logic             busy_q;
    body_t            body_q;
    logic [CNT_W-1:0] len_q;
    logic             crc_en_q;
    logic [CNT_W-1:0] idx_q;
    logic [6:0]       crc_q;
    logic [6:0]       crc_nxt;
    logic             done_q;
    logic             err_q;

    logic [CNT_W-1:0] total;
    logic             in_body;
    logic             is_last;
    logic [7:0]       cur_body;
    logic             accept;

    spi_cmd_framer_layout u_layout (
        .opcode_i    (opcode_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .size_i      (size_i),
        .clockless_i (clockless_i),
        .body_o      (lay_body),
        .len_o       (lay_len),
        .known_o     (lay_known)
    );

    spi_cmd_framer_crc7 u_crc (
        .crc_i  (crc_q),
        .byte_i (cur_body),
        .crc_o  (crc_nxt)
    );

    // Position decode for the byte currently offered.
    always_comb begin
        total    = len_q + CNT_W'(crc_en_q);
        in_body  = idx_q < len_q;
        is_last  = idx_q == (total - CNT_W'(1));
        cur_body = body_q[idx_q[SEL_W-1:0]];
        accept   = busy_q && tx_ready_i;
    end

    // Output byte: body byte or CRC trailer with bit 0 cleared.
    assign tx_data_o  = in_body ? cur_body : {crc_q, 1'b0};
    assign tx_valid_o = busy_q;
    assign done_o     = done_q;
    assign err_o      = err_q;

    // Capture on start, advance on each accepted byte, raise pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            body_q   <= '0;
            len_q    <= '0;
            crc_en_q <= 1'b0;
            idx_q    <= '0;
            crc_q    <= CRC_PRESET;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    if (lay_known) begin
                        busy_q   <= 1'b1;
                        body_q   <= lay_body;
                        len_q    <= lay_len;
                        crc_en_q <= crc_en_i;
                        idx_q    <= '0;
                        crc_q    <= CRC_PRESET;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
            end else if (accept) begin
                if (in_body) crc_q <= crc_nxt;
                idx_q <= idx_q + CNT_W'(1);
                if (is_last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_framer_chk.sv
// Protocol checker for spi_cmd_framer, attached by bind.
module spi_cmd_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic [7:0] tx_data_o,
    input logic       done_o,
    input logic       err_o
);
    // R8: a stalled byte stays offered and unchanged
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    // R9: done only follows an accepted byte and never overlaps valid
    a_r9_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !tx_valid_o && $past(tx_valid_o && tx_ready_i));

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: error pulse never coincides with an offered byte
    a_r10_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !tx_valid_o);

    // R12: outputs are quiet right after a reset cycle
    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !tx_valid_o && !done_o && !err_o);
endmodule

bind spi_cmd_framer spi_cmd_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/spi_cmd_framer_tb_top.sv
module spi_cmd_framer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [7:0]  opcode_i;
    logic [23:0] addr_i;
    logic [31:0] wdata_i;
    logic [23:0] size_i;
    logic        clockless_i;
    logic        crc_en_i;
    logic        tx_valid_o;
    logic        tx_ready_i;
    logic [7:0]  tx_data_o;
    logic        done_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] exp_b [0:9];
    int         exp_n;
    bit         exp_known;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_framer dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .opcode_i (opcode_i),
        .addr_i (addr_i), .wdata_i (wdata_i), .size_i (size_i),
        .clockless_i (clockless_i), .crc_en_i (crc_en_i),
        .tx_valid_o (tx_valid_o), .tx_ready_i (tx_ready_i), .tx_data_o (tx_data_o),
        .done_o (done_o), .err_o (err_o)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CRC7 reference, x^7+x^3+1, preset 0x7F, MSB first over n bytes
    function automatic logic [6:0] ref_crc(int n);
        logic [6:0] c = 7'h7F;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                logic top = c[6] ^ exp_b[i][b];
                c = {c[5:0], 1'b0} ^ (top ? 7'h09 : 7'h00);
            end
        return c;
    endfunction

    // Expected frame from R1..R7
    task automatic build_exp(logic [7:0] op, logic [23:0] a, logic [31:0] d,
                             logic [23:0] s, bit cl, bit ce);
        logic [7:0] ih = a[15:8] | (cl ? 8'h80 : 8'h00);
        exp_known = 1;
        exp_b[0] = op;
        case (op)
            8'hCA: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; exp_n=4; end
            8'hC7, 8'hC8: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                exp_b[4]=s[23:16]; exp_b[5]=s[15:8]; exp_b[6]=s[7:0]; exp_n=7; end
            8'hC4: begin exp_b[1]=ih; exp_b[2]=a[7:0]; exp_b[3]=8'h00; exp_n=4; end
            8'hC3: begin exp_b[1]=ih; exp_b[2]=a[7:0]; exp_b[3]=d[31:24];
                exp_b[4]=d[23:16]; exp_b[5]=d[15:8]; exp_b[6]=d[7:0]; exp_n=7; end
            8'hC9: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                exp_b[4]=d[31:24]; exp_b[5]=d[23:16]; exp_b[6]=d[15:8]; exp_b[7]=d[7:0]; exp_n=8; end
            8'hCF: begin exp_b[1]=8'hFF; exp_b[2]=8'hFF; exp_b[3]=8'hFF; exp_n=4; end
            default: begin exp_known = 0; exp_n = 0; end
        endcase
        if (exp_known && ce) begin
            exp_b[exp_n] = {ref_crc(exp_n), 1'b0};
            exp_n++;
        end
    endtask

    // Run one frame; ready_pct sets backpressure, inject restarts mid-frame
    task automatic run_frame(logic [7:0] op, logic [23:0] a, logic [31:0] d,
                             logic [23:0] s, bit cl, bit ce, int ready_pct, bit inject);
        int got = 0;
        int guard = 0;
        bit stalled = 0;
        logic [7:0] held = '0;
        build_exp(op, a, d, s, cl, ce);
        @(negedge clk);
        start_i = 1; opcode_i = op; addr_i = a; wdata_i = d; size_i = s;
        clockless_i = cl; crc_en_i = ce;
        @(negedge clk);
        start_i = 0;
        if (!exp_known) begin
            check(err_o == 1'b1, "R10 err pulse", int'(err_o), 1);
            check(tx_valid_o == 1'b0, "R10 no bytes", int'(tx_valid_o), 0);
            @(negedge clk);
            check(err_o == 1'b0, "R10 err single", int'(err_o), 0);
            check(tx_valid_o == 1'b0, "R10 still idle", int'(tx_valid_o), 0);
            return;
        end
        check(err_o == 1'b0, "R1 known opcode no err", int'(err_o), 0);
        while (got < exp_n && guard < 400) begin
            guard++;
            if (stalled)
                check(tx_valid_o && tx_data_o == held, "R8 stalled byte held",
                      int'(tx_data_o), int'(held));
            if (inject && guard == 2) begin
                start_i = 1; opcode_i = 8'hCF; addr_i = ~a; wdata_i = ~d;
                size_i = ~s; crc_en_i = ~ce;
            end else begin
                start_i = 0;
            end
            tx_ready_i = ($urandom_range(99) < ready_pct);
            check(tx_valid_o == 1'b1, "R9 valid during frame", int'(tx_valid_o), 1);
            if (tx_valid_o && tx_ready_i) begin
                check(tx_data_o == exp_b[got],
                      (got == exp_n - 1 && ce) ? "R6 crc trailer" :
                      (inject ? "R11 byte despite restart" : "R2 R3 R4 R5 frame byte"),
                      int'(tx_data_o), int'(exp_b[got]));
                got++;
                stalled = 0;
            end else begin
                stalled = tx_valid_o;
                held = tx_data_o;
            end
            @(negedge clk);
        end
        start_i = 0;
        tx_ready_i = 0;
        check(got == exp_n, ce ? "R6 length with trailer" : "R7 length without trailer", got, exp_n);
        check(done_o == 1'b1, "R9 done after last byte", int'(done_o), 1);
        check(tx_valid_o == 1'b0, "R9 valid low with done", int'(tx_valid_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done single cycle", int'(done_o), 0);
        check(tx_valid_o == 1'b0, "R11 restart left no frame", int'(tx_valid_o), 0);
    endtask

    // Watchdog: counts cycles and ends a hung run as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [0:7];
        void'($urandom(32'h5EED_1234));
        ops[0]=8'hC3; ops[1]=8'hC4; ops[2]=8'hC7; ops[3]=8'hC8;
        ops[4]=8'hC9; ops[5]=8'hCA; ops[6]=8'hCF; ops[7]=8'h00;
        rst_n = 0; start_i = 0; opcode_i = 0; addr_i = 0; wdata_i = 0;
        size_i = 0; clockless_i = 0; crc_en_i = 0; tx_ready_i = 0;
        repeat (3) @(negedge clk);
        check(!tx_valid_o && !done_o && !err_o, "R12 reset state",
              int'({tx_valid_o, done_o, err_o}), 0);
        rst_n = 1;

        // Directed corner cases
        run_frame(8'hCF, 24'h123456, 32'hDEADBEEF, 24'h0, 0, 1, 100, 0); // R4 R6
        run_frame(8'hCF, 24'h0, 32'h0, 24'h0, 0, 0, 100, 0);             // R4 R7
        run_frame(8'hC4, 24'h00_3024, 32'h0, 24'h0, 1, 1, 60, 0);        // R3 clockless
        run_frame(8'hC3, 24'h00_0010, 32'hCAFEF00D, 24'h0, 1, 0, 50, 0); // R3 write
        run_frame(8'hC4, 24'h00_8001, 32'h0, 24'h0, 0, 0, 100, 0);       // R3 addr bit 15
        run_frame(8'hC9, 24'hABCDEF, 32'h01234567, 24'h0, 0, 1, 30, 0);  // R5
        run_frame(8'hC8, 24'h00E800, 32'h0, 24'h000100, 0, 1, 70, 1);    // R2 R11
        run_frame(8'hC7, 24'h0F0F0F, 32'h0, 24'hFFFFFF, 0, 0, 40, 1);    // R2 R11
        run_frame(8'h00, 24'h0, 32'h0, 24'h0, 0, 1, 100, 0);             // R10
        run_frame(8'hC5, 24'h1, 32'h1, 24'h1, 1, 1, 100, 0);             // R10
        run_frame(8'hCA, 24'hFFFFFF, 32'h0, 24'h0, 1, 1, 100, 0);        // R1 R2

        // Constrained random mix
        for (int k = 0; k < 150; k++) begin
            logic [7:0] op = ops[$urandom_range(7)];
            if (op == 8'h00) op = 8'($urandom_range(255));
            run_frame(op, 24'($urandom), $urandom, 24'($urandom),
                      1'($urandom_range(1)), 1'($urandom_range(1)),
                      $urandom_range(20, 100), ($urandom_range(5) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule